// File: doc/BRIEF.md
# Touch-Sensor Telemetry Frame Transmitter

This block sends one snapshot of a four-key capacitive touch front end over a two-wire interface, one clock line and one data line. The acquisition logic asserts a start strobe after each measurement round. On that strobe the block latches the per-key baselines, raw counts and signed differences, together with a version byte, two flag bytes and the current key state. It then shifts all of this out as a 30-byte frame. Both lines carry output enables. They are released (enable low) between frames and driven push-pull for the whole of a frame, so an external probe can sit on pins that serve another purpose the rest of the time.

Each frame begins and ends with the same 8-bit sequence number. This lets a receiver detect dropped or torn frames. The number advances once per completed frame and wraps around. The bit period is set by a parameter: `HALF_DIV` system clocks per clock phase, and the default gives roughly 200 kbit/s at 125 MHz. A one-cycle done pulse marks the end of the last bit. The lines are released one bit period after that pulse.

Top module: `telem_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `clk_oe_o` and `dat_oe_o` are 0, and `clk_o`, `dat_o` and `done_o` are 0.
- R2: A `start_i` pulse seen while idle drives both enables high from the next cycle, with `clk_o` low and the first data bit on `dat_o`.
- R3: Every bit lasts 2*HALF_DIV cycles: HALF_DIV cycles with `clk_o` low, then HALF_DIV cycles with `clk_o` high. Bits go out most significant bit first, bytes go out in index order 0..29, and a frame holds 240 bits.
- R4: `dat_o` changes only when `clk_o` falls (or at frame start). It is stable while `clk_o` is high.
- R5: Bytes 0 and 29 both hold the frame number. It is 0 after reset, increments by one when a frame completes, and wraps from 255 to 0.
- R6: Byte 1 is `version_i` (major revision in bits 7:4, minor in bits 3:0).
- R7: Bytes 2..9 carry the baselines of keys 0..3, bytes 10..17 the raw counts, and bytes 18..25 the signed differences. Each key's 16-bit word takes two consecutive bytes, low byte first. Key k's word is bits [16k+15:16k] of the matching bus.
- R8: Bytes 26 and 27 are `flags_a_i` and `flags_b_i`.
- R9: Byte 28 is {`cal_i`, `nkeys_i[2:0]`, `touch_i[3:0]`}: calibration in bit 7, active key count in bits 6:4, touch state of key 3..0 in bits 3:0.
- R10: All frame content is latched at the accepted start. Input changes during a frame do not affect the bits sent.
- R11: A `start_i` pulse while the lines are driven is ignored. It does not restart, extend or alter the frame.
- R12: `done_o` is high for exactly the cycle after the last bit's high phase ends. Both enables fall 2*HALF_DIV cycles after `done_o` rises.
- R13: While driven but not shifting (the tail after the last bit), `clk_o` is held low and `dat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture-and-send strobe |
| version_i | input | 8 | Version byte, major in upper nibble |
| base_i | input | 64 | Four 16-bit unsigned key baselines |
| raw_i | input | 64 | Four 16-bit unsigned raw counts |
| diff_i | input | 64 | Four 16-bit signed differences |
| flags_a_i | input | 8 | First flag byte |
| flags_b_i | input | 8 | Second flag byte |
| cal_i | input | 1 | Calibration in progress |
| nkeys_i | input | 3 | Number of active keys |
| touch_i | input | 4 | Per-key touch state |
| clk_o | output | 1 | Serial clock level |
| clk_oe_o | output | 1 | Serial clock output enable |
| dat_o | output | 1 | Serial data level |
| dat_oe_o | output | 1 | Serial data output enable |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong bit or byte counter shows on `dat_o` within one bit period: a bit lands in the wrong slot, the frame is too short or too long, or `done_o` is misplaced. A per-cycle comparison against the model catches each of these on the first wrong cycle. A snapshot register that is not held through the frame shows as corrupted field bytes while the inputs are scrambled mid-frame. A wrong frame counter only shows at byte boundaries 0 and 29, and a wrap error needs more than 256 frames to appear, so the run goes past the wrap.

// File: rtl/telem_pkg.sv
package telem_pkg;
  localparam int KEYS        = 4;
  localparam int WORD_W      = 16;
  localparam int FRAME_BYTES = 30;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int BASE_OFS    = 2;
  localparam int RAW_OFS     = BASE_OFS + 2 * KEYS;
  localparam int DIFF_OFS    = RAW_OFS + 2 * KEYS;
  localparam int FLGA_IDX    = DIFF_OFS + 2 * KEYS;
  localparam int FLGB_IDX    = FLGA_IDX + 1;
  localparam int STAT_IDX    = FLGB_IDX + 1;
  localparam int LAST_IDX    = FRAME_BYTES - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } tx_state_e;

  function automatic logic [7:0] pack_status(input logic cal,
                                             input logic [2:0] nkeys,
                                             input logic [3:0] touch);
    return {cal, nkeys, touch};
  endfunction
endpackage

// File: rtl/telem_bit_timer.sv
module telem_bit_timer #(
  parameter int HALF_DIV = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)       cnt_d = '0;
    else if (tick_o)  cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < HALF_DIV); // R3
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/telem_snapshot.sv
module telem_snapshot
  import telem_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_i,
  input  logic [7:0]             version_i,
  input  logic [KEYS*WORD_W-1:0] base_i,
  input  logic [KEYS*WORD_W-1:0] raw_i,
  input  logic [KEYS*WORD_W-1:0] diff_i,
  input  logic [7:0]             flags_a_i,
  input  logic [7:0]             flags_b_i,
  input  logic                   cal_i,
  input  logic [2:0]             nkeys_i,
  input  logic [3:0]             touch_i,
  input  logic [7:0]             frame_i,
  input  logic [IDX_W-1:0]       byte_idx_i,
  output logic [7:0]             byte_o
);
  logic [WORD_W-1:0] base_q [KEYS];
  logic [WORD_W-1:0] raw_q  [KEYS];
  logic [WORD_W-1:0] diff_q [KEYS];
  logic [7:0]        ver_q, flga_q, flgb_q, stat_q;

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[k] <= '0;
        raw_q[k]  <= '0;
        diff_q[k] <= '0;
      end else if (cap_i) begin
        base_q[k] <= base_i[k*WORD_W +: WORD_W];
        raw_q[k]  <= raw_i[k*WORD_W +: WORD_W];
        diff_q[k] <= diff_i[k*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ver_q  <= '0;
      flga_q <= '0;
      flgb_q <= '0;
      stat_q <= '0;
    end else if (cap_i) begin
      ver_q  <= version_i;
      flga_q <= flags_a_i;
      flgb_q <= flags_b_i;
      stat_q <= pack_status(cal_i, nkeys_i, touch_i);
    end
  end

  logic [IDX_W-1:0]  rel;
  logic [1:0]        key;
  logic [WORD_W-1:0] word;

  always_comb begin
    rel    = byte_idx_i - IDX_W'(BASE_OFS);
    key    = rel[2:1];
    word   = '0;
    byte_o = 8'h00;
    if (byte_idx_i == '0 || byte_idx_i == IDX_W'(LAST_IDX)) begin
      byte_o = frame_i;
    end else if (byte_idx_i == IDX_W'(1)) begin
      byte_o = ver_q;
    end else if (byte_idx_i < IDX_W'(FLGA_IDX)) begin
      case (rel[4:3])
        2'd0:    word = base_q[key];
        2'd1:    word = raw_q[key];
        default: word = diff_q[key];
      endcase
      byte_o = rel[0] ? word[15:8] : word[7:0];
    end else if (byte_idx_i == IDX_W'(FLGA_IDX)) begin
      byte_o = flga_q;
    end else if (byte_idx_i == IDX_W'(FLGB_IDX)) begin
      byte_o = flgb_q;
    end else if (byte_idx_i == IDX_W'(STAT_IDX)) begin
      byte_o = stat_q;
    end
  end
endmodule

// File: rtl/telem_seq.sv
module telem_seq
  import telem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             cap_o,
  output logic             shift_o,
  output logic             sclk_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [2:0]       bit_idx_o,
  output logic [7:0]       frame_o,
  output logic             done_o
);
  tx_state_e        state_q, state_d;
  logic             phase_q, phase_d;
  logic [2:0]       bit_q, bit_d;
  logic [IDX_W-1:0] byte_q, byte_d;
  logic [7:0]       frame_q, frame_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    frame_d = frame_q;
    done_d  = 1'b0;
    cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_o   = 1'b1;
          state_d = ST_SHIFT;
          phase_d = 1'b0;
          bit_d   = '0;
          byte_d  = '0;
        end
      end
      ST_SHIFT: begin
        if (tick_i) begin
          if (!phase_q) begin
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            if (bit_q == 3'd7) begin
              bit_d = '0;
              if (byte_q == IDX_W'(LAST_IDX)) begin
                state_d = ST_TAIL;
                done_d  = 1'b1;
                frame_d = frame_q + 8'd1;
              end else begin
                byte_d = byte_q + 1'b1;
              end
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_TAIL: begin
        if (tick_i) begin
          if (!phase_q) begin
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      bit_q   <= '0;
      byte_q  <= '0;
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      frame_q <= frame_d;
      done_q  <= done_d;
    end
  end

  assign run_o      = (state_q != ST_IDLE);
  assign shift_o    = (state_q == ST_SHIFT);
  assign sclk_o     = shift_o && phase_q;
  assign byte_idx_o = byte_q;
  assign bit_idx_o  = bit_q;
  assign frame_o    = frame_q;
  assign done_o     = done_q;

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_q != $past(frame_q)) |-> (done_q && frame_q == $past(frame_q) + 8'd1)); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && byte_q != '0 && start_i) |=> (byte_q != '0)); // R11
  AST_DONE_ENTERS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_TAIL && !phase_q)); // R12
endmodule

// File: rtl/telem_frame_tx.sv
module telem_frame_tx
  import telem_pkg::*;
#(
  parameter int HALF_DIV = 312
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  version_i,
  input  logic [63:0] base_i,
  input  logic [63:0] raw_i,
  input  logic [63:0] diff_i,
  input  logic [7:0]  flags_a_i,
  input  logic [7:0]  flags_b_i,
  input  logic        cal_i,
  input  logic [2:0]  nkeys_i,
  input  logic [3:0]  touch_i,
  output logic        clk_o,
  output logic        clk_oe_o,
  output logic        dat_o,
  output logic        dat_oe_o,
  output logic        done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             tick, run, cap, shift, sclk;
  logic [IDX_W-1:0] byte_idx;
  logic [2:0]       bit_idx;
  logic [7:0]       frame_num, cur_byte;

  telem_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .tick_o (tick)
  );

  telem_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .tick_i     (tick),
    .run_o      (run),
    .cap_o      (cap),
    .shift_o    (shift),
    .sclk_o     (sclk),
    .byte_idx_o (byte_idx),
    .bit_idx_o  (bit_idx),
    .frame_o    (frame_num),
    .done_o     (done_o)
  );

  telem_snapshot u_snap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cap_i      (cap),
    .version_i  (version_i),
    .base_i     (base_i),
    .raw_i      (raw_i),
    .diff_i     (diff_i),
    .flags_a_i  (flags_a_i),
    .flags_b_i  (flags_b_i),
    .cal_i      (cal_i),
    .nkeys_i    (nkeys_i),
    .touch_i    (touch_i),
    .frame_i    (frame_num),
    .byte_idx_i (byte_idx),
    .byte_o     (cur_byte)
  );

  assign clk_o    = sclk;
  assign clk_oe_o = run;
  assign dat_oe_o = run;
  assign dat_o    = shift && cur_byte[~bit_idx];

  AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clk_oe_o && start_i) |=> (clk_oe_o && dat_oe_o && !clk_o)); // R2
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clk_o && $past(clk_o)) |-> $stable(dat_o)); // R4
  AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (clk_oe_o && !clk_o && !dat_o)); // R13
  AST_UNDRIVEN_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clk_oe_o |-> (!clk_o && !dat_o && !done_o)); // R1
endmodule

// File: tb/telem_frame_tx_tb.sv
module telem_frame_tx_tb;
  localparam int HD = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  ver, fla, flb;
  logic [63:0] basev, rawv, diffv;
  logic        cal;
  logic [2:0]  nk;
  logic [3:0]  tch;
  logic        clk_o, clk_oe, dat_o, dat_oe, done_o;

  always #4 clk = ~clk;

  telem_frame_tx #(.HALF_DIV(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .version_i(ver),
    .base_i(basev), .raw_i(rawv), .diff_i(diffv), .flags_a_i(fla),
    .flags_b_i(flb), .cal_i(cal), .nkeys_i(nk), .touch_i(tch),
    .clk_o(clk_o), .clk_oe_o(clk_oe), .dat_o(dat_o), .dat_oe_o(dat_oe),
    .done_o(done_o)
  );

  int errors = 0;
  int checks = 0;
  int frame_n = 0;
  logic [3:0] q_val[$];
  string      q_tag[$];
  logic       last_oe = 1'b0;
  logic [7:0] exp_bytes [30];
  logic [7:0] rx_bytes  [30];
  int         rx_bits = 0;
  logic       prev_clk = 1'b0;

  function automatic string tag_of(int i);
    if (i == 0 || i == 29) return "R5";
    if (i == 1)  return "R6";
    if (i < 26)  return "R7";
    if (i < 28)  return "R8";
    return "R9";
  endfunction

  function automatic logic [7:0] field_byte(int i);
    int rel, k;
    logic [15:0] w;
    if (i == 0 || i == 29) return 8'(frame_n % 256);
    if (i == 1) return ver;
    if (i >= 2 && i < 26) begin
      rel = i - 2;
      k = (rel % 8) / 2;
      if (rel < 8)       w = basev[k*16 +: 16];
      else if (rel < 16) w = rawv[k*16 +: 16];
      else               w = diffv[k*16 +: 16];
      return (rel % 2 == 1) ? w[15:8] : w[7:0];
    end
    if (i == 26) return fla;
    if (i == 27) return flb;
    return {cal, nk, tch};
  endfunction

  task automatic push_frame();
    for (int i = 0; i < 30; i++) begin
      exp_bytes[i] = field_byte(i);
      for (int b = 7; b >= 0; b--) begin
        for (int h = 0; h < HD; h++) begin q_val.push_back({1'b1, 1'b0, exp_bytes[i][b], 1'b0}); q_tag.push_back(tag_of(i)); end
        for (int h = 0; h < HD; h++) begin q_val.push_back({1'b1, 1'b1, exp_bytes[i][b], 1'b0}); q_tag.push_back("R3"); end
      end
    end
    q_val.push_back(4'b1001); q_tag.push_back("R12");
    for (int h = 1; h < 2 * HD; h++) begin q_val.push_back(4'b1000); q_tag.push_back("R13"); end
    frame_n++;
  endtask

  task automatic scramble();
    ver   = 8'($urandom);
    fla   = 8'($urandom);
    flb   = 8'($urandom);
    basev = {$urandom, $urandom};
    rawv  = {$urandom, $urandom};
    diffv = {$urandom, $urandom};
    cal   = 1'($urandom);
    nk    = 3'($urandom);
    tch   = 4'($urandom);
  endtask

  task automatic frame_end_checks();
    checks++;
    if (rx_bits != 240) begin errors++; $display("FAIL R3 bit count: got %0d exp 240", rx_bits); end
    checks++;
    if (rx_bytes[0] !== rx_bytes[29]) begin
      errors++; $display("FAIL R5 first/last frame number: got %0h/%0h exp equal", rx_bytes[0], rx_bytes[29]);
    end
    for (int i = 0; i < 30; i++) begin
      checks++;
      if (rx_bytes[i] !== exp_bytes[i]) begin
        errors++; $display("FAIL %s byte %0d: got %02h exp %02h", tag_of(i), i, rx_bytes[i], exp_bytes[i]);
      end
    end
    rx_bits = 0;
  endtask

  // One clock: compare outputs at the falling edge, then drive the next inputs.
  task automatic cycle(input logic st, input logic scr);
    logic [3:0] got, exp;
    string tg;
    @(negedge clk);
    got = {clk_oe, clk_o, dat_o, done_o};
    if (q_val.size() != 0) begin exp = q_val.pop_front(); tg = q_tag.pop_front(); end
    else begin exp = 4'b0000; tg = "R1"; end
    checks++;
    if (got !== exp || dat_oe !== clk_oe) begin
      errors++; $display("FAIL %s lines {oe,clk,dat,done}: got %b exp %b (dat_oe %b)", tg, got, exp, dat_oe);
    end
    if (clk_o && !prev_clk && rx_bits < 240) begin
      rx_bytes[rx_bits / 8][7 - rx_bits % 8] = dat_o;
      rx_bits++;
    end
    prev_clk = clk_o;
    if (done_o) frame_end_checks();
    // R10: inputs may move at any time; R11: start pulses while busy
    if (scr) scramble();
    start = st;
    if (st && !exp[3] && q_val.size() == 0) push_frame();
    last_oe = exp[3];
  endtask

  task automatic wait_idle();
    while (q_val.size() != 0 || last_oe) cycle(1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    ver = 8'h21; fla = 8'h5A; flb = 8'hC3; cal = 1'b1; nk = 3'd4; tch = 4'b1010;
    basev = 64'h0400_0311_0222_0133;
    rawv  = 64'h03F0_0300_0210_0120;
    diffv = 64'hFFF6_FFFF_000A_8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) cycle(1'b0, 1'b0);             // R1 reset state
    cycle(1'b1, 1'b0);                        // R2 first frame, fixed pattern
    for (int c = 0; c < 520; c++)             // R10 scramble, R11 stray starts
      cycle((c % 37) == 5, 1'b1);
    wait_idle();
    ver = 8'hFF; fla = 8'h00; flb = 8'hFF; cal = 1'b0; nk = 3'd2; tch = 4'b0001;
    basev = '1; rawv = '0; diffv = 64'h8000_7FFF_0001_FFFF;
    cycle(1'b1, 1'b0);                        // back-to-back start, edge values
    for (int c = 0; c < 480; c++) cycle(1'b1, 1'b0); // R11 start held high
    for (int f = 0; f < 258; f++) begin       // R5 wrap past 255
      wait_idle();
      scramble();
      cycle(1'b1, 1'b0);
    end
    wait_idle();
    repeat (4) cycle(1'b0, 1'b0);             // R12 lines released
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule